// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a synchronous request port to an external asynchronous 16-bit static RAM with a 17-bit word address. A requester presents an address, a write flag, write data and two byte-lane enables under a valid/ready handshake. The controller then runs one complete memory cycle. Read data comes back with a one-cycle response strobe.

On the memory side the controller drives:
- the address;
- a pair of chip selects, one active-low and one active-high, which are always asserted together;
- active-low write enable and output enable;
- active-low upper and lower byte enables;
- a split tri-state data bus: output value, output enable and input value.

All memory timing is counted in clock cycles set by parameters. The defaults suit a 10 ns clock and a 45 ns part:
- write-enable pulse of 4 cycles;
- 1 hold cycle after the write ends;
- read wait of 5 cycles;
- 2 idle cycles after output enable rises before the data pins may be driven again.

A write is the overlap of the selects, an active byte lane and a low write enable. Write enable is released first, and everything else is held a further cycle. Output enable stays high for the whole write, so the memory never drives against the controller.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset the memory is deselected (active-low select high, active-high select low). Write enable, output enable and both byte enables are high, the data bus is not driven, `rsp_valid` is low and `req_ready` is high.
- R2: The two chip selects are always asserted together. They are active only while a request is being served, and at least one idle cycle separates consecutive cycles.
- R3: A write holds write enable low for WE_CYC clocks (default 4, at least 35 ns) with the selects active and `req_wdata` driven on the bus. The driven data is stable for at least 28 ns before write enable rises.
- R4: Write enable rises first. The selects, byte enables, address and driven data then stay unchanged for HOLD_CYC more clocks.
- R5: Output enable is high for the entire write cycle; write enable and output enable are never low at the same time.
- R6: A read holds output enable low for RD_CYC clocks (default 5, at least 45 ns). The bus is sampled on the edge that ends that window and returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R7: `req_be` bit 0 maps to the lower byte enable and data bits 7:0. Bit 1 maps to the upper byte enable and bits 15:8. A write changes only the enabled bytes, and a read returns zero in any byte whose enable bit is 0.
- R8: The controller never drives the data bus while output enable is low. After output enable rises it waits TURN_CYC clocks (at least 18 ns) before driving the bus.
- R9: `req_ready` falls on acceptance and returns after exactly WE_CYC+HOLD_CYC clocks for a write or RD_CYC+TURN_CYC clocks for a read.
- R10: Address and byte enables are stable for as long as the memory is selected.
- R11: A request with both `req_be` bits at 0 leaves the memory in standby (both byte enables high). It changes no stored data, still takes the normal cycle time, and a read of this kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when both valid and ready are high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | AW | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data value to drive |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data bus value seen from the pins |

## Verification
A miscounted wait counter appears at the memory pins within the same cycle. The write-enable pulse is too short, output enable rises before the access time has passed, or the turnaround gap shrinks. Each of these shows up either as early-sampled filler on `rsp_rdata` or as a timing violation in the bench's memory model. A wrong lane latch corrupts data that stays hidden until the next read of that address, so every write is read back, including lane-masked and zero-lane writes. A state machine stuck outside idle holds `req_ready` low, and the cycle-count check on the handshake reports it at the end of the first affected request.

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl #(
  parameter int AW       = 17,
  parameter int WE_CYC   = 4,
  parameter int HOLD_CYC = 1,
  parameter int RD_CYC   = 5,
  parameter int TURN_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);
  localparam int M1   = (WE_CYC > HOLD_CYC) ? WE_CYC : HOLD_CYC;
  localparam int M2   = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WHOLD, S_RD, S_TURN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    be_q;
  logic          last;

  assign last      = (cnt == '0);
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      be_q       <= '0;
      mem_addr   <= '0;
      mem_cs1_n  <= 1'b1;
      mem_cs2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr  <= req_addr;
          be_q      <= req_be;
          mem_lb_n  <= ~req_be[0];
          mem_ub_n  <= ~req_be[1];
          mem_cs1_n <= 1'b0;
          mem_cs2   <= 1'b1;
          if (req_we) begin
            st         <= S_WR;
            cnt        <= CW'(WE_CYC - 1);
            mem_we_n   <= 1'b0;
            mem_dq_out <= req_wdata;
            mem_dq_oe  <= 1'b1;
          end else begin
            st       <= S_RD;
            cnt      <= CW'(RD_CYC - 1);
            mem_oe_n <= 1'b0;
          end
        end
        S_WR: if (last) begin
          st       <= S_WHOLD;
          cnt      <= CW'(HOLD_CYC - 1);
          mem_we_n <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_WHOLD: if (last) begin
          st        <= S_IDLE;
          mem_cs1_n <= 1'b1;
          mem_cs2   <= 1'b0;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_RD: if (last) begin
          st        <= S_TURN;
          cnt       <= CW'(TURN_CYC - 1);
          mem_oe_n  <= 1'b1;
          mem_cs1_n <= 1'b1;
          mem_cs2   <= 1'b0;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          rsp_valid <= 1'b1;
          rsp_rdata <= {be_q[1] ? mem_dq_in[15:8] : 8'h00,
                        be_q[0] ? mem_dq_in[7:0]  : 8'h00};
        end else cnt <= cnt - 1'b1;
        S_TURN: if (last) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
`timescale 1ns/1ps
module sram_bus_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs1_n,
  input logic          mem_cs2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic          mem_dq_oe
);
  logic sel;
  assign sel = !mem_cs1_n && mem_cs2;

  // R2
  cs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs1_n) == mem_cs2);

  // R3
  we_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (sel && mem_dq_oe));

  // R4
  we_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (sel && mem_dq_oe));

  // R5
  no_oe_in_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  no_contend_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> !mem_dq_oe);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && $past(sel)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
  .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sram_bus_ctrl;
  localparam int AW = 17, WC = 4, HC = 1, RC = 5, TC = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'h5A5A;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  sram_bus_ctrl #(.AW(AW), .WE_CYC(WC), .HOLD_CYC(HC), .RD_CYC(RC), .TURN_CYC(TC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- asynchronous memory model ----------------
  logic [15:0] smem [int];
  logic [15:0] refm [int];
  bit rd_p = 0, wr_p = 0, oe_p = 1, dqoe_p = 0, cont_p = 0;
  logic [AW-1:0] addr_p = '0, wr_addr = '0;
  logic [1:0] lanes_p = '0;
  logic [15:0] dq_p = '0;
  realtime t_rd = 0, t_wr = 0, t_d = 0, t_oer = -1000;

  function automatic logic [15:0] peek(input logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  initial begin
    #0.5;
    forever begin
      bit sel, rd, wr;
      logic [1:0] lanes;
      logic [15:0] w;
      sel   = !mem_cs1_n && mem_cs2;
      lanes = {!mem_ub_n, !mem_lb_n};
      rd    = sel && !mem_oe_n && mem_we_n && (lanes != 2'b00);
      wr    = sel && !mem_we_n && (lanes != 2'b00);
      if (!rst) begin
        if (rd && (!rd_p || mem_addr != addr_p || lanes != lanes_p)) t_rd = $realtime;
        if (!rd && rd_p)  // R6 capture edge reached after access time
          check($realtime - t_rd >= 45.0, "R6 read window ns", 32'($rtoi($realtime - t_rd)), 32'd45);
        if (mem_oe_n && !oe_p) t_oer = $realtime;
        if (mem_dq_oe && !dqoe_p)  // R8 turnaround
          check($realtime - t_oer >= 18.0, "R8 turnaround ns", 32'($rtoi($realtime - t_oer)), 32'd18);
        if (rd && mem_dq_oe && !cont_p) check(1'b0, "R8 bus contention", 32'd1, 32'd0);
        cont_p = rd && mem_dq_oe;
        if (wr && !wr_p) begin
          t_wr = $realtime; wr_addr = mem_addr;
          check(mem_oe_n, "R5 oe high at write start", 32'(mem_oe_n), 32'd1);
        end
        if (!wr && wr_p) begin
          check($realtime - t_wr >= 35.0, "R3 write pulse ns", 32'($rtoi($realtime - t_wr)), 32'd35);
          check($realtime - t_d >= 28.0, "R3 data setup ns", 32'($rtoi($realtime - t_d)), 32'd28);
          check(addr_p == wr_addr, "R10 address stable in write", 32'(addr_p), 32'(wr_addr));
          w = peek(smem, int'(addr_p));
          if (lanes_p[0]) w[7:0]  = dq_p[7:0];
          if (lanes_p[1]) w[15:8] = dq_p[15:8];
          smem[int'(addr_p)] = w;
        end
        if (mem_dq_out != dq_p) t_d = $realtime;
      end
      w = peek(smem, int'(mem_addr));
      if (rd) begin
        mem_dq_in[7:0]  = !lanes[0] ? 8'h5A : (($realtime - t_rd >= 45.0) ? w[7:0]  : 8'hB0);
        mem_dq_in[15:8] = !lanes[1] ? 8'h5A : (($realtime - t_rd >= 45.0) ? w[15:8] : 8'hB0);
      end else mem_dq_in = 16'h5A5A;
      rd_p = rd; wr_p = wr; oe_p = mem_oe_n; dqoe_p = mem_dq_oe;
      addr_p = mem_addr; lanes_p = lanes; dq_p = mem_dq_out;
      #1;
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q[$];

  always @(negedge clk) if (!rst && rsp_valid) begin
    if (exp_q.size() == 0) check(1'b0, "R6 unexpected response", 32'(rsp_rdata), 32'd0);
    else begin
      logic [15:0] e;
      e = exp_q.pop_front();
      check(rsp_rdata == e, "R7 read data", 32'(rsp_rdata), 32'(e));
    end
  end

  task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    int n;
    logic [15:0] w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    w = peek(refm, int'(a));
    if (we) begin
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      refm[int'(a)] = w;
    end else begin
      exp_q.push_back({be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00});
    end
    @(posedge clk); #1;
    req_valid = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 100);
    // R9 busy window
    check((n - 1) == (we ? WC + HC : RC + TC), "R9 busy cycles", 32'(n - 1), 32'(we ? WC + HC : RC + TC));
  endtask

  // R2 selects idle between cycles
  int idle_sel_bad = 0;
  always @(negedge clk) if (!rst && req_ready && (!mem_cs1_n || mem_cs2)) idle_sel_bad++;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1 && rsp_valid == 0, "R1 ready/rsp", {30'd0, req_ready, rsp_valid}, 32'h2);
    check(mem_cs1_n == 1 && mem_cs2 == 0, "R1 deselected", {30'd0, mem_cs1_n, mem_cs2}, 32'h2);
    check(mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe, "R1 strobes",
          {27'd0, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 32'h1E);
    rst = 0;

    // R3 R7 full word and lane writes with readback
    do_req(1, 17'h00010, 16'h1234, 2'b11);
    do_req(0, 17'h00010, 16'h0000, 2'b11);
    do_req(1, 17'h00010, 16'hFFAB, 2'b01);
    do_req(0, 17'h00010, 16'h0000, 2'b11);
    do_req(1, 17'h00010, 16'hCDFF, 2'b10);
    do_req(0, 17'h00010, 16'h0000, 2'b11);
    do_req(0, 17'h00010, 16'h0000, 2'b01);
    do_req(0, 17'h00010, 16'h0000, 2'b10);
    // boundary addresses
    do_req(1, 17'h1FFFF, 16'hBEEF, 2'b11);
    do_req(1, 17'h00000, 16'h0F0F, 2'b11);
    do_req(0, 17'h1FFFF, 16'h0000, 2'b11);
    do_req(0, 17'h00000, 16'h0000, 2'b11);
    // R11 zero-lane requests
    do_req(1, 17'h1FFFF, 16'h1111, 2'b00);
    do_req(0, 17'h1FFFF, 16'h0000, 2'b11);
    do_req(0, 17'h1FFFF, 16'h0000, 2'b00);
    check(smem[int'(17'h1FFFF)] == 16'hBEEF, "R11 standby write kept data",
          32'(smem[int'(17'h1FFFF)]), 32'hBEEF);
    // mixed traffic: R4 R8 R10 turnarounds in both directions
    for (int i = 0; i < 40; i++)
      do_req((i % 3) != 2, AW'(17'h00100 + (i % 6)), 16'hA000 ^ 16'(i * 16'h0123), 2'(i));
    for (int i = 0; i < 6; i++)
      do_req(0, AW'(17'h00100 + i), 16'h0000, 2'b11);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6 all responses returned", 32'(exp_q.size()), 32'd0);
    check(idle_sel_bad == 0, "R2 deselected while idle", 32'(idle_sel_bad), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule